// File: doc/BRIEF.md
# MSI Vector Capture Controller

This block sits behind the inbound write path of a PCIe root port. It turns message-signalled interrupt writes into pending vector bits. Each inbound write carries a 64-bit address, split into a low and a high word, and a data word. When the address equals a programmable target address, the low half of the data word is taken as a vector number. That number selects one bit in a bank of per-group status registers. The vector space is split into groups of 32 vectors, eight groups by default, which gives 256 vectors.

Every group has three registers that software programs through a simple register-bus slave: an enable word, a mask word and a write-one-to-clear status word. A read-only view of the unmasked pending bits is also provided. The block drives one combined interrupt line. Software reads the pending view of each group, services the vectors it finds there, and clears them by writing ones to the status word.

Top module: `msi_vec_capture`

## Requirements
- R1: After reset every enable word is 0, every mask word is all ones, every status word is 0, both target-address words are 0 and irq_out is low.
- R2: Group g places its enable word at register byte address 12*g, its mask word at 12*g+4 and its status word at 12*g+8. The target-address low word is at 0x80 and the high word is at 0x84. The read-only pending word of group g is at 0xC0+4*g. reg_rdata shows the addressed word in the cycle after reg_ren. A read of any other address returns 0, and writes to such addresses and to the pending words change nothing.
- R3: An inbound write (in_valid high) matches when in_addr equals the low target word and in_addr_hi equals the high target word. Its vector number v = in_data[15:0] sets bit v%32 of the status word of group v/32.
- R4: A matching write sets its status bit only if the corresponding enable bit is 1. A write to a disabled vector is dropped.
- R5: A matching write whose vector number is 256 or more (at least 32 times the group count) changes no status bit.
- R6: Status words are write-one-to-clear. Written one bits clear the corresponding status bits, and written zero bits leave them unchanged.
- R7: The pending word of a group reads status AND NOT mask. The mask does not stop a vector from being captured into status.
- R8: irq_out is high in the cycle after the state change while some group has a bit set in status and in enable and clear in mask, and low otherwise.
- R9: When a captured vector and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: An inbound write whose low or high address word differs from the target changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound write strobe, one cycle per write |
| in_addr | input | 32 | Inbound write address, low word |
| in_addr_hi | input | 32 | Inbound write address, high word |
| in_data | input | 32 | Inbound write data; bits 15:0 carry the vector number |
| reg_addr | input | 8 | Register byte address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_ren | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_ren |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong group or bit index moves a vector into the wrong status word. That shows on the first read of the status word after a single capture, which is why the sweep sends every vector on its own and reads its group straight back. A status bit that fails to set or fails to clear, or a wrong enable or mask gate, shows on irq_out in the very next cycle. It also shows in the pending word on the next read. Missing gating on the target address or on the vector range only shows as a stray status bit, so those cases are followed by reads of all groups.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
   localparam int unsigned GRP_BITS      = 32;
   localparam int unsigned GRP_STRIDE    = 12;
   localparam int unsigned OFF_ENABLE    = 0;
   localparam int unsigned OFF_MASK      = 4;
   localparam int unsigned OFF_STATUS    = 8;
   localparam int unsigned TARGET_LO_OFF = 'h80;
   localparam int unsigned TARGET_HI_OFF = 'h84;
   localparam int unsigned PEND_BASE     = 'hC0;
   localparam int unsigned MAX_GROUPS    = 10;

   typedef struct packed {
      logic en;
      logic mask;
      logic sts;
   } grp_wr_t;
endpackage

// File: rtl/msi_hit_decode.sv
module msi_hit_decode
   import msi_cap_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned VEC_SEL_W  = 16
) (
   input  logic                                  in_valid,
   input  logic [31:0]                           in_addr,
   input  logic [31:0]                           in_addr_hi,
   input  logic [31:0]                           in_data,
   input  logic [31:0]                           target_lo,
   input  logic [31:0]                           target_hi,
   output logic                                  hit_any,
   output logic [NUM_GROUPS-1:0][GRP_BITS-1:0]   set_req
);
   localparam int unsigned NUM_VEC = NUM_GROUPS * GRP_BITS;
   localparam int unsigned GSW     = VEC_SEL_W - 5;

   logic [VEC_SEL_W-1:0] vec;
   logic [GSW-1:0]       grp_idx;
   logic [4:0]           bit_idx;
   logic                 addr_eq;
   logic                 in_range;
   logic                 unused_data;

   assign vec         = in_data[VEC_SEL_W-1:0];
   assign grp_idx     = vec[VEC_SEL_W-1:5];
   assign bit_idx     = vec[4:0];
   assign unused_data = ^in_data[31:VEC_SEL_W];
   assign addr_eq     = (in_addr == target_lo) && (in_addr_hi == target_hi);
   assign in_range    = {1'b0, vec} < (VEC_SEL_W+1)'(NUM_VEC);
   assign hit_any     = in_valid && addr_eq && in_range;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sel
      always_comb begin
         set_req[g] = '0;
         if (hit_any && (grp_idx == GSW'(g)))
            set_req[g][bit_idx] = 1'b1;
      end
   end
endmodule

// File: rtl/msi_group_bank.sv
module msi_group_bank
   import msi_cap_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  grp_wr_t             wr,
   input  logic [GRP_BITS-1:0] wdata,
   input  logic [GRP_BITS-1:0] set_req,
   output logic [GRP_BITS-1:0] enable_q,
   output logic [GRP_BITS-1:0] mask_q,
   output logic [GRP_BITS-1:0] status_q,
   output logic [GRP_BITS-1:0] pending,
   output logic                fire
);
   logic [GRP_BITS-1:0] clr_bits;
   logic [GRP_BITS-1:0] take_bits;

   assign clr_bits  = wr.sts ? wdata : '0;
   assign take_bits = set_req & enable_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= '0;
         mask_q   <= '1;
         status_q <= '0;
      end else begin
         if (wr.en)   enable_q <= wdata;
         if (wr.mask) mask_q   <= wdata;
         status_q <= (status_q & ~clr_bits) | take_bits;
      end
   end

   assign pending = status_q & ~mask_q;
   assign fire    = |(pending & enable_q);

   // R4: new status bits only appear where enable was set
   a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0));

   // R6: a written one with no competing capture clears the bit
   a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.sts && ((wdata & ~take_bits) != '0))
      |=> ((status_q & $past(wdata & ~take_bits)) == '0));

   // R9: a capture always lands, even against a clear
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (take_bits != '0) |=> ((status_q & $past(take_bits)) == $past(take_bits)));
endmodule

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
   import msi_cap_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned REG_AW     = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [REG_AW-1:0]                   reg_addr,
   input  logic                                reg_wen,
   input  logic [31:0]                         reg_wdata,
   input  logic                                reg_ren,
   input  logic [NUM_GROUPS-1:0][GRP_BITS-1:0] enable_q,
   input  logic [NUM_GROUPS-1:0][GRP_BITS-1:0] mask_q,
   input  logic [NUM_GROUPS-1:0][GRP_BITS-1:0] status_q,
   input  logic [NUM_GROUPS-1:0][GRP_BITS-1:0] pending,
   output grp_wr_t [NUM_GROUPS-1:0]            grp_wr,
   output logic [31:0]                         target_lo,
   output logic [31:0]                         target_hi,
   output logic [31:0]                         reg_rdata
);
   logic [NUM_GROUPS-1:0] sel_en, sel_mask, sel_sts, sel_pend;
   logic                  sel_lo, sel_hi, any_sel;
   logic [31:0]           rd_mux;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
      assign sel_en[g]   = reg_addr == REG_AW'(g*GRP_STRIDE + OFF_ENABLE);
      assign sel_mask[g] = reg_addr == REG_AW'(g*GRP_STRIDE + OFF_MASK);
      assign sel_sts[g]  = reg_addr == REG_AW'(g*GRP_STRIDE + OFF_STATUS);
      assign sel_pend[g] = reg_addr == REG_AW'(PEND_BASE + 4*g);
      assign grp_wr[g].en   = reg_wen && sel_en[g];
      assign grp_wr[g].mask = reg_wen && sel_mask[g];
      assign grp_wr[g].sts  = reg_wen && sel_sts[g];
   end

   assign sel_lo  = reg_addr == REG_AW'(TARGET_LO_OFF);
   assign sel_hi  = reg_addr == REG_AW'(TARGET_HI_OFF);
   assign any_sel = sel_lo || sel_hi || (|sel_en) || (|sel_mask)
                    || (|sel_sts) || (|sel_pend);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target_lo <= '0;
         target_hi <= '0;
      end else if (reg_wen) begin
         if (sel_lo) target_lo <= reg_wdata;
         if (sel_hi) target_hi <= reg_wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (sel_lo) rd_mux = target_lo;
      if (sel_hi) rd_mux = target_hi;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (sel_en[g])   rd_mux = enable_q[g];
         if (sel_mask[g]) rd_mux = mask_q[g];
         if (sel_sts[g])  rd_mux = status_q[g];
         if (sel_pend[g]) rd_mux = pending[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       reg_rdata <= '0;
      else if (reg_ren) reg_rdata <= rd_mux;
   end

   // R2: unmapped reads return zero on the next cycle
   a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_ren && !any_sel) |=> (reg_rdata == '0));
endmodule

// File: rtl/msi_vec_capture.sv
module msi_vec_capture
   import msi_cap_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned REG_AW     = 8,
   parameter int unsigned VEC_SEL_W  = 16,
   parameter bit          IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       in_addr,
   input  logic [31:0]       in_addr_hi,
   input  logic [31:0]       in_data,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_ren,
   output logic [31:0]       reg_rdata,
   output logic              irq_out
);
   initial begin
      assert (NUM_GROUPS >= 1 && NUM_GROUPS <= MAX_GROUPS)
         else $error("NUM_GROUPS must lie in 1..%0d", MAX_GROUPS);
      assert (REG_AW >= 8) else $error("REG_AW must be at least 8");
      assert (VEC_SEL_W > 5 && VEC_SEL_W <= 32)
         else $error("VEC_SEL_W must lie in 6..32");
      assert ((1 << (VEC_SEL_W-5)) >= NUM_GROUPS)
         else $error("VEC_SEL_W too narrow for NUM_GROUPS");
   end

   logic [NUM_GROUPS-1:0][GRP_BITS-1:0] set_req;
   logic [NUM_GROUPS-1:0][GRP_BITS-1:0] enable_q, mask_q, status_q, pending;
   logic [NUM_GROUPS-1:0]               fire;
   grp_wr_t [NUM_GROUPS-1:0]            grp_wr;
   logic [31:0]                         target_lo, target_hi;
   logic                                hit_any;
   logic                                irq_next;

   msi_reg_decode #(.NUM_GROUPS(NUM_GROUPS), .REG_AW(REG_AW)) u_dec (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
      .reg_wdata(reg_wdata), .reg_ren(reg_ren), .enable_q(enable_q),
      .mask_q(mask_q), .status_q(status_q), .pending(pending),
      .grp_wr(grp_wr), .target_lo(target_lo), .target_hi(target_hi),
      .reg_rdata(reg_rdata)
   );

   msi_hit_decode #(.NUM_GROUPS(NUM_GROUPS), .VEC_SEL_W(VEC_SEL_W)) u_hit (
      .in_valid(in_valid), .in_addr(in_addr), .in_addr_hi(in_addr_hi),
      .in_data(in_data), .target_lo(target_lo), .target_hi(target_hi),
      .hit_any(hit_any), .set_req(set_req)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
      msi_group_bank u_bank (
         .clk(clk), .rst_n(rst_n), .wr(grp_wr[g]), .wdata(reg_wdata),
         .set_req(set_req[g]), .enable_q(enable_q[g]), .mask_q(mask_q[g]),
         .status_q(status_q[g]), .pending(pending[g]), .fire(fire[g])
      );
   end

   assign irq_next = |fire;

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= irq_next;
      end
   end else begin : g_irq_comb
      assign irq_out = irq_next;

      // R8: the line only rises after a capture or a register write
      a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_out) |-> $past(hit_any || reg_wen));
   end
endmodule

// File: tb/msi_vec_capture_test.sv
`timescale 1ns/1ps
module msi_vec_capture_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] in_addr, in_addr_hi, in_data;
   logic [7:0]  reg_addr;
   logic        reg_wen, reg_ren;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [31:0] m_en [8];
   logic [31:0] m_mask [8];
   logic [31:0] m_sts [8];
   logic [31:0] m_lo, m_hi;

   always #2.5 clk = ~clk;

   msi_vec_capture uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .in_addr_hi(in_addr_hi), .in_data(in_data), .reg_addr(reg_addr),
      .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_ren(reg_ren),
      .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic exp_irq();
      logic r = 1'b0;
      for (int g = 0; g < 8; g++) r |= |(m_sts[g] & m_en[g] & ~m_mask[g]);
      return r;
   endfunction

   task automatic model_wr(logic [7:0] a, logic [31:0] d);
      for (int g = 0; g < 8; g++) begin
         if (a == 8'(g*12))     m_en[g]   = d;
         if (a == 8'(g*12 + 4)) m_mask[g] = d;
         if (a == 8'(g*12 + 8)) m_sts[g]  = m_sts[g] & ~d;
      end
      if (a == 8'h80) m_lo = d;
      if (a == 8'h84) m_hi = d;
   endtask

   task automatic model_msi(logic [31:0] hi, logic [31:0] lo, logic [31:0] d);
      int v = int'(d[15:0]);
      if (hi == m_hi && lo == m_lo && v < 256)
         if (m_en[v/32][v%32]) m_sts[v/32][v%32] = 1'b1;
   endtask

   task automatic reg_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0;
      model_wr(a, d);
   endtask

   task automatic reg_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_ren = 1'b1;
      @(negedge clk);
      d = reg_rdata; reg_ren = 1'b0;
   endtask

   task automatic msi(logic [31:0] hi, logic [31:0] lo, logic [31:0] d);
      @(negedge clk);
      in_addr_hi = hi; in_addr = lo; in_data = d; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      model_msi(hi, lo, d);
   endtask

   task automatic check_group(string req, int g);
      logic [31:0] d;
      reg_read(8'(g*12), d);      chk({req, " enable"}, d, m_en[g]);
      reg_read(8'(g*12 + 4), d);  chk({req, " mask"}, d, m_mask[g]);
      reg_read(8'(g*12 + 8), d);  chk({req, " status"}, d, m_sts[g]);
      reg_read(8'(8'hC0 + 4*g), d); chk({req, " pending"}, d, m_sts[g] & ~m_mask[g]);
   endtask

   task automatic check_all(string req);
      for (int g = 0; g < 8; g++) check_group(req, g);
      chk({req, " irq"}, {31'b0, irq_out}, {31'b0, exp_irq()});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] T;
      T = 32'hFEE0_1000;
      in_valid = 0; in_addr = 0; in_addr_hi = 0; in_data = 0;
      reg_addr = 0; reg_wen = 0; reg_wdata = 0; reg_ren = 0;
      for (int g = 0; g < 8; g++) begin
         m_en[g] = '0; m_mask[g] = '1; m_sts[g] = '0;
      end
      m_lo = '0; m_hi = '0;
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {31'b0, irq_out}, 32'd0);
      check_all("R1");
      reg_read(8'h80, d); chk("R1 target lo", d, 32'd0);
      reg_read(8'h84, d); chk("R1 target hi", d, 32'd0);

      // R2 target registers and unmapped space
      reg_write(8'h80, T);
      reg_write(8'h84, 32'd0);
      reg_read(8'h80, d); chk("R2 target lo", d, T);
      reg_read(8'h60, d); chk("R2 unmapped 0x60", d, 32'd0);
      reg_read(8'hFC, d); chk("R2 unmapped 0xFC", d, 32'd0);
      reg_read(8'h02, d); chk("R2 unaligned", d, 32'd0);

      // R3 / R8 / R6 sweep of every vector with everything enabled
      for (int g = 0; g < 8; g++) begin
         reg_write(8'(g*12), 32'hFFFF_FFFF);
         reg_write(8'(g*12 + 4), 32'd0);
      end
      for (int v = 0; v < 256; v++) begin
         msi(32'd0, T, 32'(v));
         chk("R8 irq after capture", {31'b0, irq_out}, 32'd1);
         reg_read(8'((v/32)*12 + 8), d);
         chk("R3 vector bit", d, 32'd1 << (v%32));
         reg_write(8'((v/32)*12 + 8), 32'd1 << (v%32));
         chk("R6 irq after clear", {31'b0, irq_out}, 32'd0);
      end
      check_all("R3 after sweep");

      // R5 out-of-range vector numbers
      msi(32'd0, T, 32'd256);
      msi(32'd0, T, 32'd300);
      msi(32'd0, T, 32'h0000_FFFF);
      check_all("R5");
      chk("R5 irq", {31'b0, irq_out}, 32'd0);

      // R10 address mismatch, low and high words
      msi(32'd0, T + 32'd4, 32'd7);
      msi(32'd1, T, 32'd7);
      check_all("R10");
      chk("R10 irq", {31'b0, irq_out}, 32'd0);

      // R4 disabled vectors dropped
      reg_write(8'd24, 32'h0000_FFFF);
      msi(32'd0, T, 32'd84);
      check_group("R4 disabled", 2);
      msi(32'd0, T, 32'd67);
      check_group("R4 enabled", 2);
      chk("R4 irq", {31'b0, irq_out}, 32'd1);

      // R7 mask hides pending but not capture
      reg_write(8'd28, 32'h0000_0008);
      chk("R7 irq masked", {31'b0, irq_out}, 32'd0);
      msi(32'd0, T, 32'd69);
      check_group("R7 masked capture", 2);
      reg_write(8'd28, 32'd0);
      chk("R7 irq unmasked", {31'b0, irq_out}, 32'd1);

      // R8 enable cleared with status still set
      reg_write(8'd24, 32'd0);
      chk("R8 irq disabled", {31'b0, irq_out}, 32'd0);
      reg_read(8'd32, d); chk("R8 status kept", d, 32'h0000_0028);
      reg_write(8'd24, 32'hFFFF_FFFF);
      chk("R8 irq re-enabled", {31'b0, irq_out}, 32'd1);

      // R6 writing zero keeps, all ones clears
      reg_write(8'd32, 32'd0);
      reg_read(8'd32, d); chk("R6 zero write", d, 32'h0000_0028);
      reg_write(8'd32, 32'hFFFF_FFFF);
      reg_read(8'd32, d); chk("R6 all ones", d, 32'd0);
      chk("R6 irq", {31'b0, irq_out}, 32'd0);

      // R2 pending word is read-only
      msi(32'd0, T, 32'd200);
      reg_write(8'hC0 + 8'd24, 32'hFFFF_FFFF);
      check_group("R2 pending write ignored", 6);

      // R9 capture and clear on the same bit in one cycle
      msi(32'd0, T, 32'd241);
      @(negedge clk);
      in_addr_hi = 32'd0; in_addr = T; in_data = 32'd241; in_valid = 1'b1;
      reg_addr = 8'd92; reg_wdata = 32'hFFFF_FFFF; reg_wen = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; reg_wen = 1'b0;
      reg_read(8'd92, d); chk("R9 set wins", d, 32'h0002_0000);
      chk("R9 irq", {31'b0, irq_out}, 32'd1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule